// File: doc/BRIEF.md
# UART Receive-Line Wake-Up Sequencer

This block brings a sleeping system back from power-down when the UART receive line falls. When the power-down indication is high and the wake, UART, receiver and receive-interrupt enables are all set, the block arms itself. A falling edge on the synchronized receive line then raises a wake request, which tells the clock and power logic to bring the system up.

After the wake event the block counts a fixed settling window on the system clock. During that window it raises a gate that tells the UART datapath to discard whatever arrives on the line. Further edges on the line in this window do not restart the count. When the window ends, the block gives a one-cycle resume-ready pulse. In that same cycle it raises a wake interrupt, but only if both the peripheral and the global interrupt enables were set at the wake event. With either of them clear, the system still wakes but no interrupt is raised.

Oscillator control, clock gating, the transmit line and the UART data path are outside this block.

Top module: `uart_rx_wake`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, wake_req, rx_ignore, resume_ready and wake_irq are all 0.
- R2: With pwr_down high and wake_en, uart_en, rx_en and rx_irq_en all 1, a 1-to-0 transition on rx_pin raises wake_req on the third rising clock edge after the transition. Each falling edge passes through two synchronizer flops and one edge register.
- R3: With pwr_down low, a falling edge on rx_pin never raises wake_req.
- R4: Once raised, wake_req stays high for exactly DELAY clock cycles (default 1024) and then falls.
- R5: rx_ignore is high in exactly the cycles in which wake_req is high, and low otherwise.
- R6: resume_ready is a one-cycle pulse in the first cycle after wake_req falls.
- R7: wake_irq is high only in the resume_ready cycle, and only if uart_irq_en and glb_irq_en were both 1 in the cycle in which the wake edge was accepted. It is never high during the settling window.
- R8: Further falling or rising edges on rx_pin while wake_req is high do not restart or extend the settling window.
- R9: If any one of wake_en, uart_en, rx_en or rx_irq_en is 0 when the edge arrives, no wake occurs, even if all four were set when power-down began.
- R10: Only a falling edge wakes the block. If rx_pin is already low when power-down begins, nothing happens until the line rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_pin | input | 1 | UART receive line, asynchronous, idles high |
| pwr_down | input | 1 | System is in power-down |
| uart_en | input | 1 | UART enable |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| wake_en | input | 1 | Receive-line wake-up enable |
| uart_irq_en | input | 1 | Peripheral UART interrupt enable |
| glb_irq_en | input | 1 | Global interrupt enable |
| wake_req | output | 1 | Wake request, held high through the settling window |
| rx_ignore | output | 1 | Discard received data while high |
| resume_ready | output | 1 | One-cycle pulse: normal operation may resume |
| wake_irq | output | 1 | One-cycle wake interrupt request |

## Verification
A sequencer left in the wrong state shows up at the ports within a few cycles. A missed arm or disarm shows as wake_req failing to rise, or rising when it should not, on the third edge after the line falls. A counter that restarts or ends early shows as a settling window of the wrong length, so every wake is timed from rising edge to resume pulse. An interrupt qualifier captured at the wrong moment, or lost, shows as a wrong wake_irq in the single resume cycle, so each combination of enables is run through a full window.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;
  typedef enum logic [1:0] {
    WK_IDLE     = 2'd0,
    WK_ARMED    = 2'd1,
    WK_SETTLING = 2'd2,
    WK_RESUMED  = 2'd3
  } wk_state_t;
endpackage

// File: rtl/wk_rx_sync.sv
module wk_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= rx_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rx_fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/wk_settle_cnt.sv
module wk_settle_cnt #(
  parameter int DELAY = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                  cnt_d = '0;
    else if (cnt_q != LAST_VAL) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = run & (cnt_q == LAST_VAL);
endmodule

// File: rtl/wk_seq_fsm.sv
module wk_seq_fsm
  import uart_rx_wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic arm_ok,
  input  logic irq_ok,
  input  logic rx_fall,
  input  logic settle_last,
  output logic settling,
  output logic resumed,
  output logic irq_fire
);
  wk_state_t state_q, state_d;
  logic      irq_q, irq_d;
  logic      take_edge;

  assign take_edge = (state_q == WK_ARMED) & pwr_down & arm_ok & rx_fall;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WK_IDLE:     if (pwr_down & arm_ok) state_d = WK_ARMED;
      WK_ARMED: begin
        if (!pwr_down || !arm_ok) state_d = WK_IDLE;
        else if (rx_fall)         state_d = WK_SETTLING;
      end
      WK_SETTLING: if (settle_last) state_d = WK_RESUMED;
      WK_RESUMED:  state_d = WK_IDLE;
      default:     state_d = WK_IDLE;
    endcase
  end

  always_comb begin
    irq_d = irq_q;
    if (take_edge) irq_d = irq_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_edge) irq_q <= irq_d;
    end
  end

  assign settling = (state_q == WK_SETTLING);
  assign resumed  = (state_q == WK_RESUMED);
  assign irq_fire = resumed & irq_q;
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int DELAY       = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic pwr_down,
  input  logic uart_en,
  input  logic rx_en,
  input  logic rx_irq_en,
  input  logic wake_en,
  input  logic uart_irq_en,
  input  logic glb_irq_en,
  output logic wake_req,
  output logic rx_ignore,
  output logic resume_ready,
  output logic wake_irq
);
  logic rx_fall, settle_last, settling, resumed, irq_fire;
  logic arm_ok, irq_ok;

  assign arm_ok = wake_en & uart_en & rx_en & rx_irq_en;
  assign irq_ok = uart_irq_en & glb_irq_en;

  wk_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .rx_async(rx_pin), .rx_fall(rx_fall)
  );

  wk_settle_cnt #(.DELAY(DELAY)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(settling), .last(settle_last)
  );

  wk_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .arm_ok(arm_ok),
    .irq_ok(irq_ok), .rx_fall(rx_fall), .settle_last(settle_last),
    .settling(settling), .resumed(resumed), .irq_fire(irq_fire)
  );

  assign wake_req     = settling;
  assign rx_ignore    = settling;
  assign resume_ready = resumed;
  assign wake_irq     = irq_fire;
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk #(
  parameter int DELAY = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic uart_en,
  input logic rx_en,
  input logic rx_irq_en,
  input logic wake_en,
  input logic wake_req,
  input logic resume_ready,
  input logic wake_irq
);
  localparam int KW = $clog2(DELAY + 2) + 1;
  logic [KW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (wake_req) hi_cnt <= hi_cnt + 1'b1;
    else               hi_cnt <= '0;
  end

  p_wake_needs_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(pwr_down));
  p_wake_needs_enables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(wake_en & uart_en & rx_en & rx_irq_en));
  p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> (hi_cnt == KW'(DELAY)));
  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (hi_cnt < KW'(DELAY)));
  p_ready_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req) |-> resume_ready);
  p_ready_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ready |=> !resume_ready);
  p_irq_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (resume_ready && !wake_req));
endmodule

bind uart_rx_wake uart_rx_wake_chk #(.DELAY(DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .uart_en(uart_en),
  .rx_en(rx_en), .rx_irq_en(rx_irq_en), .wake_en(wake_en),
  .wake_req(wake_req), .resume_ready(resume_ready), .wake_irq(wake_irq)
);

// File: tb/uart_rx_wake_tb_top.sv
`timescale 1ns/1ps
module uart_rx_wake_tb_top;
  localparam int DELAY = 1024;
  localparam int NV = 8;
  // {wake_en, uart_en, rx_en, rx_irq_en, uart_irq_en, glb_irq_en}
  localparam logic [5:0] VEC [NV] = '{
    6'b111111, 6'b111110, 6'b111101, 6'b011111,
    6'b101111, 6'b110111, 6'b111011, 6'b111100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_pin = 1'b1, pwr_down = 1'b0;
  logic uart_en = 1'b0, rx_en = 1'b0, rx_irq_en = 1'b0, wake_en = 1'b0;
  logic uart_irq_en = 1'b0, glb_irq_en = 1'b0;
  logic wake_req, rx_ignore, resume_ready, wake_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_wake #(.DELAY(DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .pwr_down(pwr_down),
    .uart_en(uart_en), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
    .wake_en(wake_en), .uart_irq_en(uart_irq_en), .glb_irq_en(glb_irq_en),
    .wake_req(wake_req), .rx_ignore(rx_ignore),
    .resume_ready(resume_ready), .wake_irq(wake_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [5:0] c);
    {wake_en, uart_en, rx_en, rx_irq_en, uart_irq_en, glb_irq_en} = c;
  endtask

  // Arms, drops rx, and times a whole window when a wake is expected.
  task automatic run_wake(input logic [5:0] c, input bit bounce);
    logic exp_w, exp_i;
    exp_w = &c[5:2];
    exp_i = exp_w & c[1] & c[0];
    set_cfg(c); rx_pin = 1'b1; pwr_down = 1'b0; cyc(3);
    pwr_down = 1'b1; cyc(2);
    rx_pin = 1'b0;
    cyc(2);
    chk("R2 no early wake", wake_req, 1'b0);
    cyc(1);
    chk(exp_w ? "R2 wake on third edge" : "R9 no wake with an enable clear", wake_req, exp_w);
    chk("R5 ignore follows window", rx_ignore, exp_w);
    if (exp_w) begin
      if (bounce) begin
        cyc(100); rx_pin = 1'b1; cyc(5); rx_pin = 1'b0; cyc(5); rx_pin = 1'b1;
        cyc(3); rx_pin = 1'b0; cyc(DELAY - 1 - 113);
      end else begin
        cyc(DELAY - 1);
      end
      chk("R4 still in window", wake_req, 1'b1);
      chk("R8 window not extended", resume_ready, 1'b0);
      chk("R7 no irq in window", wake_irq, 1'b0);
      cyc(1);
      chk("R4 window ended", wake_req, 1'b0);
      chk("R5 ignore dropped", rx_ignore, 1'b0);
      chk("R6 resume pulse", resume_ready, 1'b1);
      chk("R7 irq qualified", wake_irq, exp_i);
      cyc(1);
      chk("R6 pulse one cycle", resume_ready, 1'b0);
      chk("R7 irq one cycle", wake_irq, 1'b0);
    end else begin
      cyc(10);
      chk("R9 still asleep", wake_req, 1'b0);
      chk("R9 no resume", resume_ready, 1'b0);
    end
    pwr_down = 1'b0; rx_pin = 1'b1; cyc(4);
  endtask

  initial begin
    cyc(3);
    chk("R1 wake_req in reset", wake_req, 1'b0);
    chk("R1 rx_ignore in reset", rx_ignore, 1'b0);
    chk("R1 resume in reset", resume_ready, 1'b0);
    chk("R1 irq in reset", wake_irq, 1'b0);
    rst_n = 1'b1; cyc(1);
    chk("R1 wake_req after release", wake_req, 1'b0);
    chk("R1 resume after release", resume_ready, 1'b0);

    for (int i = 0; i < NV; i++) run_wake(VEC[i], 1'b0);

    // R8: line toggles during the window
    run_wake(6'b111111, 1'b1);

    // R3: falling edge while awake
    set_cfg(6'b111111); pwr_down = 1'b0; cyc(2);
    rx_pin = 1'b0; cyc(3);
    chk("R3 no wake when awake", wake_req, 1'b0);
    cyc(5);
    chk("R3 still no wake", wake_req, 1'b0);
    rx_pin = 1'b1; cyc(4);

    // R9: enable cleared after arming
    pwr_down = 1'b1; cyc(3);
    rx_en = 1'b0; cyc(1);
    rx_pin = 1'b0; cyc(3);
    chk("R9 disarmed by late clear", wake_req, 1'b0);
    cyc(5);
    chk("R9 disarmed stays asleep", wake_req, 1'b0);
    pwr_down = 1'b0; rx_pin = 1'b1; rx_en = 1'b1; cyc(4);

    // R10: line already low at power-down
    rx_pin = 1'b0; cyc(4);
    pwr_down = 1'b1; cyc(8);
    chk("R10 low level does not wake", wake_req, 1'b0);
    rx_pin = 1'b1; cyc(4);
    chk("R10 rising edge does not wake", wake_req, 1'b0);
    rx_pin = 1'b0; cyc(3);
    chk("R10 fresh fall wakes", wake_req, 1'b1);

    // R1: reset in mid-window
    cyc(50);
    rst_n = 1'b0; cyc(1);
    chk("R1 reset clears wake_req", wake_req, 1'b0);
    chk("R1 reset clears rx_ignore", rx_ignore, 1'b0);
    rst_n = 1'b1; pwr_down = 1'b0; rx_pin = 1'b1; cyc(4);
    chk("R1 quiet after reset", resume_ready | wake_irq, 1'b0);
    done = 1'b1;
  end

  initial begin
    int k;
    for (k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule